// File: doc/BRIEF.md
# Panel Power Sequencer

This block brings an LCD panel up and takes it down again in a fixed, timed order. It drives two panel pins, a power-enable line and an active-low panel reset. It also issues a scripted series of 8-bit-address, 16-bit-data register writes to an external serial register writer, using a start/done handshake. Between steps it inserts millisecond waits. A millisecond tick comes from an internal divider whose length is a parameter, so a short divider can stand in for real time.

Both sequences come from one internal script store. Each entry is one of four kinds: a pin action, a register write, a wait of N milliseconds, or an end marker. The power-up script begins at entry 0 and the power-down script begins at entry 20. A pulse on `on_req` starts the power-up script when the block is idle with the panel off. A pulse on `off_req` starts the power-down script when the block is idle with the panel on. Every other request is ignored. `seq_busy` shows that a script is running. `pnl_on` shows that the last finished script was the power-up one.

Top module: `panel_pwr_seq`

## Requirements
- R1: During and after reset, `pnl_pwr_en`=0, `pnl_rst_n`=1, `wr_start`=0, `seq_busy`=0 and `pnl_on`=0.
- R2: An accepted power-up request raises `seq_busy` one cycle after the request cycle. It raises `pnl_pwr_en` two cycles after the request cycle and drives `pnl_rst_n` low three cycles after it. The panel reset is low only while `pnl_pwr_en` is high.
- R3: `pnl_rst_n` stays low for exactly 10×TICK_DIV+2 cycles. The first register write starts TICK_DIV+2 cycles after the reset rises, which is a 1 ms wait.
- R4: The power-up writes are issued in this order, as (address, data):
  - (09,0000)
  - 10 ms wait, then (09,4000) and (0A,2000)
  - 40 ms wait, then (09,4055)
  - 50 ms wait, then (01,409D), (02,0204), (03,0100) and (04,3000)
  - 60 ms wait, then (09,4A55) and (05,5003)
- R5: A write preceded by an N ms wait starts N×TICK_DIV+3 cycles after the cycle in which the previous write's `wr_done` was high. A write with no wait before it starts 2 cycles after that cycle.
- R6: `wr_start` is high for a single cycle. `wr_addr` and `wr_data` hold their values until `wr_done` arrives. No later entry runs before `wr_done`.
- R7: Two cycles after the final power-up write's done cycle, `seq_busy` is 0 and `pnl_on` is 1.
- R8: The power-down script writes (09,4055), (05,4003) and (0A,0000). It then waits 10 ms and writes (09,4000). Its first write starts 2 cycles after the request cycle. `pnl_pwr_en` falls 2 cycles after the last done cycle. One cycle after that, `seq_busy` and `pnl_on` are 0.
- R9: Requests are ignored while `seq_busy` is 1. `on_req` is ignored while the panel is on, and `off_req` is ignored while it is off. An ignored request causes no `seq_busy`, no write and no change in `pnl_on`.
- R10: When both requests arrive in the same idle cycle, only the one that matches the panel state is taken. A request in the cycle in which the end marker retires is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| on_req | input | 1 | Power-up request pulse |
| off_req | input | 1 | Power-down request pulse |
| wr_done | input | 1 | Register writer finished the current write |
| wr_start | output | 1 | One-cycle start of a register write |
| wr_addr | output | 8 | Register address of the current write |
| wr_data | output | 16 | Register data of the current write |
| pnl_pwr_en | output | 1 | Panel power enable (high = powered) |
| pnl_rst_n | output | 1 | Panel reset, active low |
| seq_busy | output | 1 | A script is running |
| pnl_on | output | 1 | Panel is powered up and configured |

## Verification
Two functions can fall into the same cycle. A new request can arrive in the cycle in which the end marker of a script retires. An ignored request can also arrive while a millisecond wait is counting down. The bench drives an `off_req` in exactly the cycle after the last power-up done, when the end marker is being executed. It then requires `seq_busy` to stay low with no write for several cycles. The bench also pulses both requests in the middle of the panel-reset wait, and then requires the reset-low width and every later write gap to keep their exact cycle counts.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  localparam int REG_AW    = 8;
  localparam int REG_DW    = 16;
  localparam int PC_W      = 5;
  localparam int ROM_DEPTH = 1 << PC_W;

  localparam logic [PC_W-1:0]   ON_BASE  = PC_W'(0);
  localparam logic [PC_W-1:0]   OFF_BASE = PC_W'(20);
  localparam logic [REG_AW-1:0] PIN_PWR  = REG_AW'(0);
  localparam logic [REG_AW-1:0] PIN_RST  = REG_AW'(1);

  typedef enum logic [1:0] {
    OP_END  = 2'd0,
    OP_PIN  = 2'd1,
    OP_WR   = 2'd2,
    OP_WAIT = 2'd3
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [REG_AW-1:0] arg;
    logic [REG_DW-1:0] val;
  } entry_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_WRW   = 2'd2,
    S_MSW   = 2'd3
  } state_e;

  function automatic entry_t mk(input op_e o, input int a, input int v);
    entry_t e;
    e.op  = o;
    e.arg = a[REG_AW-1:0];
    e.val = v[REG_DW-1:0];
    return e;
  endfunction

  // Power-up script from ON_BASE, power-down script from OFF_BASE.
  function automatic entry_t script_at(input logic [PC_W-1:0] idx);
    case (idx)
      5'd0:  script_at = mk(OP_PIN,  0,     1);
      5'd1:  script_at = mk(OP_PIN,  1,     0);
      5'd2:  script_at = mk(OP_WAIT, 0,    10);
      5'd3:  script_at = mk(OP_PIN,  1,     1);
      5'd4:  script_at = mk(OP_WAIT, 0,     1);
      5'd5:  script_at = mk(OP_WR,   8'h09, 16'h0000);
      5'd6:  script_at = mk(OP_WAIT, 0,    10);
      5'd7:  script_at = mk(OP_WR,   8'h09, 16'h4000);
      5'd8:  script_at = mk(OP_WR,   8'h0A, 16'h2000);
      5'd9:  script_at = mk(OP_WAIT, 0,    40);
      5'd10: script_at = mk(OP_WR,   8'h09, 16'h4055);
      5'd11: script_at = mk(OP_WAIT, 0,    50);
      5'd12: script_at = mk(OP_WR,   8'h01, 16'h409D);
      5'd13: script_at = mk(OP_WR,   8'h02, 16'h0204);
      5'd14: script_at = mk(OP_WR,   8'h03, 16'h0100);
      5'd15: script_at = mk(OP_WR,   8'h04, 16'h3000);
      5'd16: script_at = mk(OP_WAIT, 0,    60);
      5'd17: script_at = mk(OP_WR,   8'h09, 16'h4A55);
      5'd18: script_at = mk(OP_WR,   8'h05, 16'h5003);
      5'd19: script_at = mk(OP_END,  0,     0);
      5'd20: script_at = mk(OP_WR,   8'h09, 16'h4055);
      5'd21: script_at = mk(OP_WR,   8'h05, 16'h4003);
      5'd22: script_at = mk(OP_WR,   8'h0A, 16'h0000);
      5'd23: script_at = mk(OP_WAIT, 0,    10);
      5'd24: script_at = mk(OP_WR,   8'h09, 16'h4000);
      5'd25: script_at = mk(OP_PIN,  0,     0);
      default: script_at = mk(OP_END, 0,    0);
    endcase
  endfunction

endpackage

// File: rtl/pwr_tick_gen.sv
module pwr_tick_gen #(
  parameter int TICK_DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);

  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign tick   = (cnt_q == LAST);
  assign cnt_en = 1'b1;

  always_comb begin
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pwr_script_rom.sv
module pwr_script_rom
  import pwr_seq_pkg::*;
(
  input  logic [PC_W-1:0] idx,
  output entry_t          ent
);

  entry_t table_w [ROM_DEPTH];

  for (genvar i = 0; i < ROM_DEPTH; i++) begin : g_row
    assign table_w[i] = script_at(PC_W'(i));
  end

  assign ent = table_w[idx];

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              on_req,
  input  logic              off_req,
  input  logic              wr_done,
  input  logic              tick,
  input  entry_t            ent,
  output logic [PC_W-1:0]   pc,
  output logic              tick_restart,
  output logic              wr_start,
  output logic [REG_AW-1:0] wr_addr,
  output logic [REG_DW-1:0] wr_data,
  output logic              pnl_pwr_en,
  output logic              pnl_rst_n,
  output logic              seq_busy,
  output logic              pnl_on
);

  localparam logic [PC_W-1:0]   PC_ONE  = PC_W'(1);
  localparam logic [REG_DW-1:0] CNT_ONE = REG_DW'(1);

  state_e            state_q, state_d;
  logic [PC_W-1:0]   pc_q, pc_d;
  logic [REG_DW-1:0] cnt_q, cnt_d;
  logic              start_q, start_d;
  logic [REG_AW-1:0] addr_q;
  logic [REG_DW-1:0] data_q;
  logic              pwr_q, pwr_d;
  logic              prst_q, prst_d;
  logic              on_q, on_d;
  logic              dir_q, dir_d;
  logic              cmd_en;

  always_comb begin
    state_d      = state_q;
    pc_d         = pc_q;
    cnt_d        = cnt_q;
    start_d      = 1'b0;
    pwr_d        = pwr_q;
    prst_d       = prst_q;
    on_d         = on_q;
    dir_d        = dir_q;
    cmd_en       = 1'b0;
    tick_restart = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (on_req && !on_q) begin
          pc_d    = ON_BASE;
          dir_d   = 1'b1;
          state_d = S_FETCH;
        end else if (off_req && on_q) begin
          pc_d    = OFF_BASE;
          dir_d   = 1'b0;
          state_d = S_FETCH;
        end
      end
      S_FETCH: begin
        case (ent.op)
          OP_PIN: begin
            if (ent.arg == PIN_RST) prst_d = ent.val[0];
            else                    pwr_d  = ent.val[0];
            pc_d = pc_q + PC_ONE;
          end
          OP_WR: begin
            start_d = 1'b1;
            cmd_en  = 1'b1;
            state_d = S_WRW;
          end
          OP_WAIT: begin
            cnt_d        = ent.val;
            tick_restart = 1'b1;
            state_d      = S_MSW;
          end
          default: begin
            on_d    = dir_q;
            state_d = S_IDLE;
          end
        endcase
      end
      S_WRW: begin
        if (wr_done) begin
          pc_d    = pc_q + PC_ONE;
          state_d = S_FETCH;
        end
      end
      default: begin
        if (tick) begin
          if (cnt_q <= CNT_ONE) begin
            pc_d    = pc_q + PC_ONE;
            state_d = S_FETCH;
          end else begin
            cnt_d = cnt_q - CNT_ONE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      pc_q    <= '0;
      cnt_q   <= '0;
      start_q <= 1'b0;
      pwr_q   <= 1'b0;
      prst_q  <= 1'b1;
      on_q    <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      cnt_q   <= cnt_d;
      start_q <= start_d;
      pwr_q   <= pwr_d;
      prst_q  <= prst_d;
      on_q    <= on_d;
      dir_q   <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (cmd_en) begin
      addr_q <= ent.arg;
      data_q <= ent.val;
    end
  end

  assign pc         = pc_q;
  assign wr_start   = start_q;
  assign wr_addr    = addr_q;
  assign wr_data    = data_q;
  assign pnl_pwr_en = pwr_q;
  assign pnl_rst_n  = prst_q;
  assign seq_busy   = (state_q != S_IDLE);
  assign pnl_on     = on_q;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q); // R6
  AST_START_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (state_q == S_WRW)); // R6
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WRW && !start_q) |-> ($stable(addr_q) && $stable(data_q))); // R6
  AST_RST_UNDER_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    !prst_q |-> pwr_q); // R2
  AST_IDLE_STATUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE) |=> $stable(on_q)); // R9

endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int TICK_DIV = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              on_req,
  input  logic              off_req,
  input  logic              wr_done,
  output logic              wr_start,
  output logic [REG_AW-1:0] wr_addr,
  output logic [REG_DW-1:0] wr_data,
  output logic              pnl_pwr_en,
  output logic              pnl_rst_n,
  output logic              seq_busy,
  output logic              pnl_on
);

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic            tick;
  logic            tick_restart;
  logic [PC_W-1:0] pc;
  entry_t          ent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pwr_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .restart (tick_restart),
    .tick    (tick)
  );

  pwr_script_rom u_rom (
    .idx (pc),
    .ent (ent)
  );

  pwr_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .on_req       (on_req),
    .off_req      (off_req),
    .wr_done      (wr_done),
    .tick         (tick),
    .ent          (ent),
    .pc           (pc),
    .tick_restart (tick_restart),
    .wr_start     (wr_start),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .pnl_pwr_en   (pnl_pwr_en),
    .pnl_rst_n    (pnl_rst_n),
    .seq_busy     (seq_busy),
    .pnl_on       (pnl_on)
  );

endmodule

// File: tb/panel_pwr_seq_tb.sv
module panel_pwr_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 3;
  localparam int LIMIT      = 5000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        on_req, off_req, wr_done;
  logic        wr_start;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;
  logic        pnl_pwr_en, pnl_rst_n, seq_busy, pnl_on;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  // Expected power-up writes (R4) and the wait in ms before each one.
  int on_addr [10] = '{'h09, 'h09, 'h0A, 'h09, 'h01, 'h02, 'h03, 'h04, 'h09, 'h05};
  int on_data [10] = '{'h0000, 'h4000, 'h2000, 'h4055, 'h409D, 'h0204, 'h0100, 'h3000, 'h4A55, 'h5003};
  int on_wait [10] = '{1, 10, 0, 40, 50, 0, 0, 0, 60, 0};
  // Expected power-down writes (R8).
  int off_addr [4] = '{'h09, 'h05, 'h0A, 'h09};
  int off_data [4] = '{'h4055, 'h4003, 'h0000, 'h4000};
  int off_wait [4] = '{0, 0, 0, 10};

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  panel_pwr_seq #(.TICK_DIV(TDIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req),
    .wr_done(wr_done), .wr_start(wr_start), .wr_addr(wr_addr),
    .wr_data(wr_data), .pnl_pwr_en(pnl_pwr_en), .pnl_rst_n(pnl_rst_n),
    .seq_busy(seq_busy), .pnl_on(pnl_on)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic cur(input int which);
    case (which)
      0:       return pnl_pwr_en;
      1:       return pnl_rst_n;
      default: return seq_busy;
    endcase
  endfunction

  task automatic wait_sig(input int which, input logic val, output int at);
    int g = 0;
    while (cur(which) !== val && g < LIMIT) begin
      step();
      g++;
    end
    at = cyc;
  endtask

  task automatic pulse_req(input bit on_b, input bit off_b, output int q);
    on_req  = on_b;
    off_req = off_b;
    q = cyc;
    step();
    on_req  = 1'b0;
    off_req = 1'b0;
  endtask

  task automatic do_write(input int a, input int d, input int ref_c, input int gap,
                          input int lat, input string req, output int done_at);
    int g = 0;
    while (wr_start !== 1'b1 && g < LIMIT) begin
      step();
      g++;
    end
    chk(cyc - ref_c == gap, "R5 write start gap", cyc - ref_c, gap);
    chk(wr_addr == a[7:0] && wr_data == d[15:0], req, {wr_addr, wr_data}, {a[7:0], d[15:0]});
    for (int k = 1; k < lat; k++) begin
      step();
      if (k == 1) chk(wr_start == 1'b0, "R6 start single cycle", wr_start, 0);
    end
    chk(wr_addr == a[7:0] && wr_data == d[15:0], "R6 command held", {wr_addr, wr_data}, {a[7:0], d[15:0]});
    wr_done = 1'b1;
    done_at = cyc;
    step();
    wr_done = 1'b0;
  endtask

  task automatic idle_quiet(input int n, input logic exp_on, input string req);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      if (seq_busy || wr_start || pnl_on !== exp_on) bad++;
      step();
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic run_on(input int lat, input bit both);
    int q, t, fall, rise, done_at;
    pulse_req(1'b1, both, q);
    chk(seq_busy == 1'b1, "R2 busy after request", seq_busy, 1);
    wait_sig(0, 1'b1, t);
    chk(t - q == 2, "R2 power enable timing", t - q, 2);
    wait_sig(1, 1'b0, fall);
    chk(fall - q == 3, "R2 panel reset low timing", fall - q, 3);
    chk(pnl_pwr_en == 1'b1, "R2 reset only when powered", pnl_pwr_en, 1);
    step();
    on_req  = 1'b1;   // R9: ignored in the middle of a wait
    off_req = 1'b1;
    step();
    on_req  = 1'b0;
    off_req = 1'b0;
    wait_sig(1, 1'b1, rise);
    chk(rise - fall == 10*TDIV + 2, "R3 reset low width", rise - fall, 10*TDIV + 2);
    do_write(on_addr[0], on_data[0], rise, TDIV + 2, lat, "R3 R4 first write", done_at);
    for (int i = 1; i < 10; i++) begin
      int gap = (on_wait[i] != 0) ? on_wait[i]*TDIV + 3 : 2;
      do_write(on_addr[i], on_data[i], done_at, gap, lat, "R4 power-up write", done_at);
    end
    off_req = 1'b1;   // R10: lands in the cycle the end marker retires
    step();
    off_req = 1'b0;
    chk(cyc - done_at == 2, "R7 completion timing", cyc - done_at, 2);
    chk(seq_busy == 1'b0 && pnl_on == 1'b1, "R7 status after power-up", {seq_busy, pnl_on}, 2'b01);
    idle_quiet(10, 1'b1, "R10 request at end marker ignored");
  endtask

  task automatic run_off(input int lat, input bit both);
    int q, t, done_at;
    pulse_req(both, 1'b1, q);
    chk(seq_busy == 1'b1, "R8 busy after request", seq_busy, 1);
    done_at = q;
    for (int i = 0; i < 4; i++) begin
      int gap = (off_wait[i] != 0) ? off_wait[i]*TDIV + 3 : 2;
      do_write(off_addr[i], off_data[i], done_at, gap, lat, "R8 power-down write", done_at);
    end
    wait_sig(0, 1'b0, t);
    chk(t - done_at == 2, "R8 power enable fall", t - done_at, 2);
    wait_sig(2, 1'b0, t);
    chk(t - done_at == 3, "R8 busy fall", t - done_at, 3);
    chk(pnl_on == 1'b0 && pnl_rst_n == 1'b1, "R8 status after power-down", {pnl_on, pnl_rst_n}, 2'b01);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1 actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int q;
    rst_n   = 1'b0;
    on_req  = 1'b0;
    off_req = 1'b0;
    wr_done = 1'b0;
    repeat (3) step();
    chk(pnl_pwr_en == 0 && pnl_rst_n == 1 && wr_start == 0 && seq_busy == 0 && pnl_on == 0,
        "R1 state in reset", {pnl_pwr_en, pnl_rst_n, wr_start, seq_busy, pnl_on}, 5'b01000);
    rst_n = 1'b1;
    repeat (4) step();
    chk(pnl_pwr_en == 0 && pnl_rst_n == 1 && wr_start == 0 && seq_busy == 0 && pnl_on == 0,
        "R1 state after reset", {pnl_pwr_en, pnl_rst_n, wr_start, seq_busy, pnl_on}, 5'b01000);

    pulse_req(1'b0, 1'b1, q);   // R9: power-down while off
    idle_quiet(8, 1'b0, "R9 off request while off ignored");

    for (int li = 0; li < 3; li++) begin
      int lat = (li == 0) ? 1 : (li == 1) ? 2 : 5;
      run_on(lat, li == 2);     // R10 both requests on the last pass
      pulse_req(1'b1, 1'b0, q); // R9: power-up while on
      idle_quiet(8, 1'b1, "R9 on request while on ignored");
      run_off(lat, li == 1);    // R10 both requests while on
      idle_quiet(5, 1'b0, "R9 idle after power-down");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule